// File: doc/BRIEF.md
# Byte-Wide SPI Host with Register Access

This block is an SPI host that a processor drives through four 32-bit registers on a simple read/write bus. Each transfer moves exactly one byte in both directions. Software writes the byte to send into the transmit register. The host then clocks it out MSB first on MOSI and, at the same time, gathers eight bits from MISO. Once the transfer is over, software reads the received byte from the receive register. A ready flag in the control register shows when the shifter is idle.

Chip selects are plain level bits in the control register, one per attached device. The host never toggles them itself, so software can frame multi-byte exchanges by leaving a select asserted across several byte transfers. The configuration register holds four settings: the serial clock polarity and phase, a 5-bit prescaler code with a split encoding, and two mode bits that must both be clear for a transmit write to start a shift. It also has a self-clearing flush control, which empties the receive register.

Top module: `spi_byte_host`

## Requirements
- R1: After reset, control reads 0x0000_0002 (ready set, no select active), configuration reads 0, receive reads 0, SCLK is low and every `spi_cs_n` is high.
- R2: A write to control (offset 0x0) stores bits 16 and up as select enables, with bit 16+i for device i. `spi_cs_n[i]` is low while that bit is 1, and a control read returns those bits together with the ready flag in bit 1.
- R3: A write to transmit (offset 0x8) while ready, with configuration bits 17 and 5 both 0, starts a shift. The ready flag reads 0 from the next cycle onward.
- R4: The prescaler code p (configuration bits 4:0) gives a half-period of D clock cycles. D is 1 for p of 0 or 1, p for p from 2 to 15, 1 for p = 16, and 2*(p-16) for p from 17 to 31. A byte keeps ready low for exactly 16*D cycles.
- R5: While no shift is running, SCLK rests at the level of configuration bit 7 (CPOL).
- R6: MOSI carries bits 7 down to 0 of the written byte. With configuration bit 6 (CPHA) at 0, MISO is sampled on the odd-numbered SCLK edges (1st, 3rd, ...) and MOSI changes on the even-numbered ones. With CPHA at 1, the roles swap.
- R7: After a shift ends, a read of receive (offset 0xC) returns the eight MISO bits, the first one sampled in bit 7, with bits 31:8 zero.
- R8: A transmit write made while a shift is running is ignored. The running byte completes unchanged and no second shift follows.
- R9: A transmit write made while configuration bit 17 or bit 5 is set starts no shift. Ready stays 1 and SCLK stays still.
- R10: Writing 1 to configuration bit 9 clears the receive register to 0. Bit 9 reads 1 in the cycle after the write and 0 from the cycle after that.
- R11: Configuration bits 4:0, 5, 6, 7 and 17 read back as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | NUM_CS | Active-low device selects |

## Verification
The bench builds the host with three chip selects instead of the default two. This places a select bit outside the lowest pair, so a slip in the bit-16 offset or in the vector width shows up on `spi_cs_n`. The prescaler codes it uses reach every branch of the split decode: 0, 3, 5, 16, 17, 20 and 31. The largest of these gives a 480-cycle byte and checks that the divider counter has enough width. All four CPOL/CPHA combinations are driven against a device model that shifts on the opposite edge from where it samples.

// File: rtl/sbh_pkg.sv
package sbh_pkg;

  localparam int REG_W   = 32;
  localparam int PRESC_W = 5;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_CFG  = 4'h4;
  localparam logic [3:0] OFF_TX   = 4'h8;
  localparam logic [3:0] OFF_RX   = 4'hC;

  localparam int CTRL_RDY  = 1;
  localparam int CTRL_CS0  = 16;
  localparam int CFG_BLEN  = 5;
  localparam int CFG_CPHA  = 6;
  localparam int CFG_CPOL  = 7;
  localparam int CFG_FLUSH = 9;
  localparam int CFG_FIFO  = 17;

  typedef struct packed {
    logic               fifo_en;
    logic               cpol;
    logic               cpha;
    logic               blen;
    logic [PRESC_W-1:0] presc;
  } cfg_t;

  // Half-period of the serial clock in core cycles, from the 5-bit code.
  function automatic logic [PRESC_W-1:0] half_period(input logic [PRESC_W-1:0] code);
    logic [PRESC_W-1:0] res;
    if (code[PRESC_W-1] == 1'b0) begin
      res = (code < 2) ? PRESC_W'(1) : code;
    end else if (code[PRESC_W-2:0] == '0) begin
      res = PRESC_W'(1);
    end else begin
      res = {code[PRESC_W-2:0], 1'b0};
    end
    return res;
  endfunction

endpackage

// File: rtl/sbh_regs.sv
module sbh_regs
  import sbh_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_CS = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rx_data,
  output cfg_t              cfg,
  output logic [NUM_CS-1:0] cs_en,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              clr_rx,
  output logic              flush_flag
);

  logic wr, wr_ctrl, wr_cfg, wr_tx;
  cfg_t              cfg_q, cfg_d;
  logic [NUM_CS-1:0] cs_q, cs_d;
  logic              flush_q, flush_d;

  assign wr      = bus_en & bus_we;
  assign wr_ctrl = wr & (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_cfg  = wr & (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_tx   = wr & (bus_addr == ADDR_W'(OFF_TX));

  always_comb begin
    cfg_d   = cfg_q;
    cs_d    = cs_q;
    flush_d = 1'b0;
    if (wr_ctrl) begin
      cs_d = bus_wdata[CTRL_CS0 +: NUM_CS];
    end
    if (wr_cfg) begin
      cfg_d.presc   = bus_wdata[PRESC_W-1:0];
      cfg_d.blen    = bus_wdata[CFG_BLEN];
      cfg_d.cpha    = bus_wdata[CFG_CPHA];
      cfg_d.cpol    = bus_wdata[CFG_CPOL];
      cfg_d.fifo_en = bus_wdata[CFG_FIFO];
      flush_d       = bus_wdata[CFG_FLUSH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cs_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      cs_q    <= cs_d;
      flush_q <= flush_d;
    end
  end

  assign start      = wr_tx & ~busy & ~cfg_q.fifo_en & ~cfg_q.blen;
  assign tx_byte    = bus_wdata[BYTE_W-1:0];
  assign clr_rx     = wr_cfg & bus_wdata[CFG_FLUSH];
  assign cfg        = cfg_q;
  assign cs_en      = cs_q;
  assign flush_flag = flush_q;

  logic [REG_W-1:0] ctrl_view, cfg_view, rx_view;

  always_comb begin
    ctrl_view                      = '0;
    ctrl_view[CTRL_RDY]            = ~busy;
    ctrl_view[CTRL_CS0 +: NUM_CS]  = cs_q;
    cfg_view                       = '0;
    cfg_view[PRESC_W-1:0]          = cfg_q.presc;
    cfg_view[CFG_BLEN]             = cfg_q.blen;
    cfg_view[CFG_CPHA]             = cfg_q.cpha;
    cfg_view[CFG_CPOL]             = cfg_q.cpol;
    cfg_view[CFG_FLUSH]            = flush_q;
    cfg_view[CFG_FIFO]             = cfg_q.fifo_en;
    rx_view                        = '0;
    rx_view[BYTE_W-1:0]            = rx_data;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFF_CTRL): bus_rdata = ctrl_view;
      ADDR_W'(OFF_CFG):  bus_rdata = cfg_view;
      ADDR_W'(OFF_RX):   bus_rdata = rx_view;
      default:           bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sbh_clkdiv.sv
module sbh_clkdiv
  import sbh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [PRESC_W-1:0] half;
  logic [PRESC_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  assign half   = half_period(presc);
  assign tick   = run & (cnt_q == half - PRESC_W'(1));
  assign cnt_en = run | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = (!run || tick) ? '0 : cnt_q + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sbh_shifter.sv
module sbh_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              miso,
  input  logic              clr_rx,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_data
);

  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST = EDGE_W'(EDGES - 1);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              sample_edge;

  // Edge 0 is the leading edge; CPHA 0 samples on even edge indices.
  assign sample_edge = (edge_q[0] == cpha);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    data_d = data_q;
    if (!busy_q) begin
      sclk_d = cpol;
      if (start) begin
        busy_d = 1'b1;
        tx_d   = tx_byte;
        edge_d = '0;
        rx_d   = '0;
      end
    end else if (tick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_q + EDGE_W'(1);
      if (sample_edge) begin
        rx_d = {rx_q[BYTE_W-2:0], miso};
      end else if ((edge_q != LAST) && (edge_q != '0)) begin
        tx_d = {tx_q[BYTE_W-2:0], 1'b0};
      end
      if (edge_q == LAST) begin
        busy_d = 1'b0;
        data_d = rx_d;
      end
    end
    if (clr_rx) begin
      data_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      data_q <= data_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[BYTE_W-1];
  assign rx_data = data_q;

endmodule

// File: rtl/spi_byte_host.sv
module spi_byte_host
  import sbh_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  localparam int BYTE_W = 8;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  cfg_t              cfg;
  logic [NUM_CS-1:0] cs_en;
  logic              start, clr_rx, flush_flag, busy, tick, ready;
  logic [BYTE_W-1:0] tx_byte, rx_data;

  assign ready = ~busy;

  sbh_regs #(
    .ADDR_W(ADDR_W),
    .NUM_CS(NUM_CS),
    .BYTE_W(BYTE_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .rx_data   (rx_data),
    .cfg       (cfg),
    .cs_en     (cs_en),
    .start     (start),
    .tx_byte   (tx_byte),
    .clr_rx    (clr_rx),
    .flush_flag(flush_flag)
  );

  sbh_clkdiv u_div (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (busy),
    .presc(cfg.presc),
    .tick (tick)
  );

  sbh_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .tx_byte(tx_byte),
    .tick   (tick),
    .cpol   (cfg.cpol),
    .cpha   (cfg.cpha),
    .miso   (spi_miso),
    .clr_rx (clr_rx),
    .busy   (busy),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .rx_data(rx_data)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = ~cs_en[i];
  end

endmodule

// File: rtl/sbh_checker.sv
module sbh_checker #(
  parameter int ADDR_W = 4,
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              ready,
  input logic              cpol,
  input logic              fifo_en,
  input logic              blen,
  input logic              flush_flag,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n
);

  logic tx_wr, ctrl_wr;
  assign tx_wr   = bus_en & bus_we & (bus_addr == ADDR_W'(4'h8));
  assign ctrl_wr = bus_en & bus_we & (bus_addr == ADDR_W'(4'h0));

  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && ready && !fifo_en && !blen) |=> !ready);

  a_r9_mode_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && ready && (fifo_en || blen)) |=> ready);

  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> (sclk == $past(cpol)));

  a_r10_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_flag |=> !flush_flag);

  a_r2_select_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cs_n == ~$past(bus_wdata[16 +: NUM_CS])));

  a_r8_busy_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !ready) |=> $stable(cs_n));

endmodule

bind spi_byte_host sbh_checker #(
  .ADDR_W(ADDR_W),
  .NUM_CS(NUM_CS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ready     (ready),
  .cpol      (cfg.cpol),
  .fifo_en   (cfg.fifo_en),
  .blen      (cfg.blen),
  .flush_flag(flush_flag),
  .sclk      (spi_sclk),
  .cs_n      (spi_cs_n)
);

// File: tb/sim_spi_byte_host.sv
`timescale 1ns/1ps
module sim_spi_byte_host;

  localparam int AW  = 4;
  localparam int NCS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           b_en = 1'b0, b_we = 1'b0;
  logic [AW-1:0]  b_addr = '0;
  logic [31:0]    b_wdata = '0;
  logic [31:0]    b_rdata;
  logic           sclk, mosi;
  logic           miso = 1'b0;
  logic [NCS-1:0] cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit pha_b = 1'b0;
  int mon_done = 0;

  typedef struct {
    logic [7:0] tx;
    logic [7:0] sl;
  } item_t;
  item_t exp_q[$];

  spi_byte_host #(.ADDR_W(AW), .NUM_CS(NCS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(b_en), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    b_en = 1'b1; b_we = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_en = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    b_addr = a;
    #1 d = b_rdata;
  endtask

  function automatic int half(input int p);
    if (p < 2) return 1;
    if (p < 16) return p;
    if (p == 16) return 1;
    return 2 * (p - 16);
  endfunction

  // Monitor: device model and scoreboard for MOSI.
  initial begin
    forever begin
      item_t it;
      logic [7:0] sr, cap;
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      sr = it.sl;
      cap = '0;
      miso = pha_b ? 1'b0 : sr[7];
      for (int e = 0; e < 16; e++) begin
        @(sclk);
        if ((e % 2) == int'(pha_b)) begin
          cap = {cap[6:0], mosi};
        end else if (!pha_b && e != 15) begin
          sr = {sr[6:0], 1'b0};
          miso = sr[7];
        end else if (pha_b) begin
          miso = sr[7];
          sr = {sr[6:0], 1'b0};
        end
      end
      check(cap == it.tx, "R6 mosi byte", cap, it.tx);
      mon_done++;
    end
  end

  task automatic poll_ready(output int n, output bit first_low);
    logic [31:0] d;
    n = 0;
    first_low = 1'b0;
    forever begin
      rd(4'h0, d);
      if (n == 0) first_low = ~d[1];
      if (d[1]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic xfer(input int p, input bit pol, input bit pha, input logic [7:0] tx, input logic [7:0] sl);
    int n, target;
    bit first_low;
    logic [31:0] d;
    wr(4'h4, (32'(pol) << 7) | (32'(pha) << 6) | 32'(p));
    pha_b = pha;
    @(negedge clk);
    @(negedge clk);
    check(sclk == pol, "R5 idle level", 32'(sclk), 32'(pol));
    target = mon_done + 1;
    exp_q.push_back('{tx: tx, sl: sl});
    wr(4'h8, 32'(tx));
    poll_ready(n, first_low);
    check(first_low, "R3 ready drop", 32'(first_low), 32'd1);
    check(n == 16 * half(p), "R4 duration", n, 16 * half(p));
    wait (mon_done >= target);
    @(negedge clk);
    rd(4'hC, d);
    check(d == 32'(sl), "R7 received byte", d, 32'(sl));
  endtask

  initial begin
    logic [31:0] d;
    int n, target;
    bit first_low, quiet;
    logic s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'h0, d); check(d == 32'h2, "R1 control", d, 32'h2);
    rd(4'h4, d); check(d == 32'h0, "R1 config", d, 32'h0);
    rd(4'hC, d); check(d == 32'h0, "R1 receive", d, 32'h0);
    check(sclk == 1'b0, "R1 sclk", 32'(sclk), 32'h0);
    check(cs_n == '1, "R1 selects", 32'(cs_n), 32'h7);

    // R2 chip selects
    wr(4'h0, 32'h0005_0000);
    check(cs_n == 3'b010, "R2 select pins", 32'(cs_n), 32'h2);
    rd(4'h0, d); check(d == 32'h0005_0002, "R2 control read", d, 32'h0005_0002);
    wr(4'h0, 32'h0002_0000);
    check(cs_n == 3'b101, "R2 select pins", 32'(cs_n), 32'h5);

    // R11 configuration readback
    wr(4'h4, 32'h0002_00F3);
    rd(4'h4, d); check(d == 32'h0002_00F3, "R11 config readback", d, 32'h0002_00F3);
    wr(4'h4, 32'h0);

    // transfers over modes and prescaler branches (R3 R4 R5 R6 R7)
    xfer(0,  1'b0, 1'b0, 8'hA5, 8'h3C);
    xfer(3,  1'b0, 1'b1, 8'h81, 8'h7E);
    xfer(17, 1'b1, 1'b0, 8'hC3, 8'h5A);
    xfer(5,  1'b1, 1'b1, 8'h0F, 8'hF0);
    xfer(16, 1'b0, 1'b1, 8'hFF, 8'h00);
    xfer(20, 1'b1, 1'b0, 8'h01, 8'h80);
    xfer(31, 1'b0, 1'b0, 8'h96, 8'h69);

    // R8 write while busy is ignored
    wr(4'h4, 32'd17);
    pha_b = 1'b0;
    @(negedge clk);
    target = mon_done + 1;
    exp_q.push_back('{tx: 8'h5C, sl: 8'hB2});
    wr(4'h8, 32'h5C);
    repeat (4) @(negedge clk);
    wr(4'h8, 32'hE7);
    poll_ready(n, first_low);
    wait (mon_done >= target);
    @(negedge clk);
    rd(4'hC, d); check(d == 32'hB2, "R8 running byte kept", d, 32'hB2);
    quiet = 1'b1;
    s0 = sclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rd(4'h0, d);
      if (!d[1] || sclk != s0) quiet = 1'b0;
    end
    check(quiet, "R8 no second shift", 32'(quiet), 32'h1);

    // R9 mode bits block a start
    for (int m = 0; m < 2; m++) begin
      wr(4'h4, (m == 0) ? 32'h0002_0000 : 32'h0000_0020);
      s0 = sclk;
      wr(4'h8, 32'h33);
      quiet = 1'b1;
      for (int i = 0; i < 40; i++) begin
        rd(4'h0, d);
        if (!d[1] || sclk != s0) quiet = 1'b0;
        @(negedge clk);
      end
      check(quiet, "R9 no shift in mode", 32'(quiet), 32'h1);
    end
    wr(4'h4, 32'h0);

    // R10 flush
    rd(4'hC, d); check(d == 32'hB2, "R10 receive before flush", d, 32'hB2);
    wr(4'h4, 32'h0000_0200);
    rd(4'h4, d); check(d[9] == 1'b1, "R10 flush bit set", 32'(d[9]), 32'h1);
    @(negedge clk);
    rd(4'h4, d); check(d[9] == 1'b0, "R10 flush bit cleared", 32'(d[9]), 32'h0);
    rd(4'hC, d); check(d == 32'h0, "R10 receive cleared", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule